// File: doc/BRIEF.md
# Fractional-N Divide and Cancellation-DAC Modulator

This block produces the two digital control streams of a fractional-N frequency synthesizer, one value of each per reference clock. A first-order accumulator adds a 20-bit fraction to its running contents every cycle. Its carry raises the feedback divide value from the integer setting to the integer plus one, so the average division ratio equals the integer plus the fraction over 2^20. With a 26 MHz reference this gives a step of about 25 Hz.

The divider accumulator's leftover contents go into a second shaper. That shaper is a cascade of first-order accumulators whose order can be set to 1, 2 or 3. An error-cancellation network combines the stage carries so that only the last stage's error remains, shaped by a repeated first difference. The signed result is placed around mid-scale, scaled and clamped into an unsigned code for the phase-detector cancellation DAC.

The integer, fraction and order are captured together on a load strobe.

Top module: `fracn_modulator`

## Requirements
- R1: A clock edge with `rst_n` low clears every accumulator, every carry-history register and every configuration register. After that edge `div_val` reads 0 and `dac_code` reads mid-scale, 2^(DAC_W-1), which is 8192 by default.
- R2: On an edge with `cfg_load` high, `int_in`, `frac_in` and `order_in` are captured. The outputs of that same edge still use the previous settings. The new settings drive the outputs from the following edge on.
- R3: Each edge adds the fraction to the divider residue modulo 2^20. The carry out of that sum goes into the same registered update: `div_val` = integer + carry, where carry is 1 exactly when residue + fraction ≥ 2^20. A fraction of 0 never carries.
- R4: Start from cleared state with a fraction that is a multiple of 16. Over the 2^16 edges that follow capture, the carries sum to exactly fraction/16. In general they sum to the fraction over 2^20 edges.
- R5: Shaper stage 1 adds the divider residue as it stood before the edge. Each later stage adds the new contents of the stage before it. Every stage wraps modulo 2^20 and emits its carry.
- R6: Order code 0 selects first order, 1 selects second order, and 2 or 3 selects third order.
- R7: The shaped value is y = c1, plus (c2 − c2 of the previous edge) for order two or more, plus (c3 − 2·c3 of the previous edge + c3 of two edges back) for order three.
- R8: `dac_code` = 2^(DAC_W-1) + y·2^SCALE_SH, clamped to [0, 2^DAC_W − 1]. With the defaults (14, 11), y = 4 gives 16383.
- R9: With order code 0, `dac_code` takes only the values 8192 and 10240.
- R10: Changing the order or the fraction with a load clears no accumulator and no carry history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Capture strobe for integer, fraction and order |
| frac_in | input | FRAC_W (20) | Fractional word, in units of 2^-20 |
| int_in | input | INT_W (8) | Integer part of the division ratio |
| order_in | input | 2 | Shaper order code |
| div_val | output | INT_W+1 (9) | Per-cycle feedback divide value |
| dac_code | output | DAC_W (14) | Cancellation DAC control code |

## Verification
The hardest output to reach is the clamped top code. It needs the third-order combination in which all three carries fire together, the previous c2 and c3 are zero and the c3 of two edges back is one. No single input produces that pattern. The stimulus holds order code 3 with a fraction near 0.6154 for 65536 cycles, which walks the stage residues through a long non-repeating pattern. The bench counts how often its model predicts the clamp and requires at least one hit. The same run gives the exact carry sum for the average-ratio check.

// File: rtl/fracn_pkg.sv
// Shared definitions for the fractional-N modulator.
// Assumes the cancellation network is written for exactly three stages.
package fracn_pkg;
    typedef enum logic [1:0] {
        ORD_ONE   = 2'd0,
        ORD_TWO   = 2'd1,
        ORD_THREE = 2'd2,
        ORD_TOP   = 2'd3
    } mash_order_e;

    localparam int MASH_STAGES = 3;
    // signed width of the combined shaped value, range -3..4
    localparam int SHAPED_W    = 4;
endpackage

// File: rtl/fracn_div_ctl.sv
// Divider-control accumulator: a first-order accumulator whose carry
// dithers the feedback divide value between int and int+1.
// Assumes frac_i and int_i are already registered configuration.
module fracn_div_ctl #(
    parameter int FRAC_W = 20,
    parameter int INT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [INT_W-1:0]  int_i,
    output logic [FRAC_W-1:0] residue_o,
    output logic [INT_W:0]    div_o
);
    logic [FRAC_W:0] sum_w;

    // modular sum of residue and fraction, top bit is the carry
    always_comb begin
        sum_w = {1'b0, residue_o} + {1'b0, frac_i};
    end

    // update residue and the registered divide value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            residue_o <= '0;
            div_o     <= '0;
        end else begin
            residue_o <= sum_w[FRAC_W-1:0];
            div_o     <= {1'b0, int_i} + {{INT_W{1'b0}}, sum_w[FRAC_W]};
        end
    end
endmodule

// File: rtl/fracn_stage.sv
// One first-order stage of the noise-shaping cascade. It exposes the
// new contents (sum_o) combinationally so the next stage can add them in
// the same cycle. Assumes in_i is stable before the clock edge.
module fracn_stage #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W-1:0] acc_q;

    // add input to stored contents, split off the carry
    always_comb begin
        {carry_o, sum_o} = {1'b0, acc_q} + {1'b0, in_i};
    end

    // store new contents
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum_o;
    end

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o == (sum_o < in_i));
endmodule

// File: rtl/fracn_cancel.sv
// Error-cancellation network for a three-stage cascade. Stage k's carry
// passes through k-1 first differences, then the enabled terms are added.
// Carry history is kept every cycle whatever the order selected.
module fracn_cancel
    import fracn_pkg::*;
#(
    parameter int Y_W = SHAPED_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MASH_STAGES-1:0] carry_i,
    input  mash_order_e           order_i,
    output logic signed [Y_W-1:0] y_o
);
    logic c2_p, c3_p, c3_pp;
    logic signed [Y_W-1:0] t1, d2, d3;

    // keep one edge of c2 history and two edges of c3 history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2_p  <= 1'b0;
            c3_p  <= 1'b0;
            c3_pp <= 1'b0;
        end else begin
            c2_p  <= carry_i[1];
            c3_p  <= carry_i[2];
            c3_pp <= c3_p;
        end
    end

    // form the differenced terms
    always_comb begin
        t1 = $signed({{(Y_W-1){1'b0}}, carry_i[0]});
        d2 = $signed({{(Y_W-1){1'b0}}, carry_i[1]})
           - $signed({{(Y_W-1){1'b0}}, c2_p});
        d3 = $signed({{(Y_W-1){1'b0}}, carry_i[2]})
           - $signed({{(Y_W-2){1'b0}}, c3_p, 1'b0})
           + $signed({{(Y_W-1){1'b0}}, c3_pp});
    end

    // pick the terms enabled by the order
    always_comb begin
        case (order_i)
            ORD_ONE: y_o = t1;
            ORD_TWO: y_o = t1 + d2;
            default: y_o = t1 + d2 + d3;
        endcase
    end

    // R7
    one_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order_i == ORD_ONE) |-> (y_o >= 0 && y_o <= 1));
    // R7
    two_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order_i == ORD_TWO) |-> (y_o >= -1 && y_o <= 2));
endmodule

// File: rtl/fracn_dac_map.sv
// Places the signed shaped value around mid-scale, scales it by a power
// of two and clamps it into an unsigned DAC code. Purely combinational.
module fracn_dac_map #(
    parameter int DAC_W    = 14,
    parameter int SCALE_SH = 11,
    parameter int Y_W      = 4
) (
    input  logic signed [Y_W-1:0] y_i,
    output logic [DAC_W-1:0]      code_o
);
    localparam int WIDE = DAC_W + Y_W + 1;
    localparam logic signed [WIDE-1:0] MID_W = WIDE'(2 ** (DAC_W - 1));
    localparam logic signed [WIDE-1:0] TOP_W = WIDE'(2 ** DAC_W - 1);

    logic signed [WIDE-1:0] y_ext, wide_w;

    // offset, scale and clamp
    always_comb begin
        y_ext  = {{(WIDE-Y_W){y_i[Y_W-1]}}, y_i};
        wide_w = MID_W + (y_ext <<< SCALE_SH);
        if (wide_w < 0)          code_o = '0;
        else if (wide_w > TOP_W) code_o = TOP_W[DAC_W-1:0];
        else                     code_o = wide_w[DAC_W-1:0];
    end
endmodule

// File: rtl/fracn_modulator.sv
// Top of the fractional-N modulator. It captures the configuration on a
// load strobe, dithers the divide value with a first-order accumulator,
// and shapes that accumulator's residue through a cascade of selectable
// order into a registered cancellation DAC code.
// Assumes one update per reference clock and a synchronous active-low reset.
module fracn_modulator
    import fracn_pkg::*;
#(
    parameter int FRAC_W   = 20,
    parameter int INT_W    = 8,
    parameter int DAC_W    = 14,
    parameter int SCALE_SH = DAC_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic [INT_W-1:0]  int_in,
    input  logic [1:0]        order_in,
    output logic [INT_W:0]    div_val,
    output logic [DAC_W-1:0]  dac_code
);
    localparam logic [DAC_W-1:0] MID_CODE  = DAC_W'(2 ** (DAC_W - 1));
    localparam logic [DAC_W-1:0] STEP_CODE = DAC_W'(2 ** SCALE_SH);

    logic [FRAC_W-1:0] frac_cfg;
    logic [INT_W-1:0]  int_cfg;
    mash_order_e       ord_cfg;
    logic [FRAC_W-1:0] residue;

    logic [FRAC_W-1:0]      st_in  [MASH_STAGES];
    logic [FRAC_W-1:0]      st_sum [MASH_STAGES];
    logic [MASH_STAGES-1:0] st_carry;
    logic signed [SHAPED_W-1:0] shaped;
    logic [DAC_W-1:0]       code_w;

    // capture configuration on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_cfg <= '0;
            int_cfg  <= '0;
            ord_cfg  <= ORD_ONE;
        end else if (cfg_load) begin
            frac_cfg <= frac_in;
            int_cfg  <= int_in;
            ord_cfg  <= mash_order_e'(order_in);
        end
    end

    fracn_div_ctl #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .frac_i    (frac_cfg),
        .int_i     (int_cfg),
        .residue_o (residue),
        .div_o     (div_val)
    );

    for (genvar k = 0; k < MASH_STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign st_in[k] = residue;
        end else begin : g_link
            assign st_in[k] = st_sum[k-1];
        end
        fracn_stage #(.W(FRAC_W)) u_st (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_i    (st_in[k]),
            .sum_o   (st_sum[k]),
            .carry_o (st_carry[k])
        );
    end

    fracn_cancel #(.Y_W(SHAPED_W)) u_cancel (
        .clk     (clk),
        .rst_n   (rst_n),
        .carry_i (st_carry),
        .order_i (ord_cfg),
        .y_o     (shaped)
    );

    fracn_dac_map #(.DAC_W(DAC_W), .SCALE_SH(SCALE_SH), .Y_W(SHAPED_W)) u_map (
        .y_i    (shaped),
        .code_o (code_w)
    );

    // register the DAC code
    always_ff @(posedge clk) begin
        if (!rst_n) dac_code <= MID_CODE;
        else        dac_code <= code_w;
    end

    // R3
    div_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (div_val == {1'b0, $past(int_cfg)} ||
                          div_val == {1'b0, $past(int_cfg)} + 1'b1));
    // R9
    one_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ord_cfg) == ORD_ONE) |->
            (dac_code == MID_CODE || dac_code == MID_CODE + STEP_CODE));
endmodule

// File: tb/fracn_modulator_test.sv
`timescale 1ns/1ps
module fracn_modulator_test;
    localparam int FW = 20;
    localparam int IW = 8;
    localparam int DW = 14;
    localparam int SH = 11;
    localparam int FULL = 1 << FW;
    localparam int MID = 1 << (DW - 1);
    localparam int TOPC = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [FW-1:0] frac_in = '0;
    logic [IW-1:0] int_in = '0;
    logic [1:0] order_in = '0;
    logic [IW:0] div_val;
    logic [DW-1:0] dac_code;

    always #2 clk = ~clk;

    fracn_modulator uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .frac_in(frac_in),
        .int_in(int_in), .order_in(order_in), .div_val(div_val), .dac_code(dac_code)
    );

    int vectors = 0;
    int miscompares = 0;
    string phase = "R1";

    // behavioural reference state
    int m_frac = 0, m_int = 0, m_ord = 0, m_res = 0;
    int m_s[3] = '{0, 0, 0};
    int h2[$];
    int h3[$];
    int exp_div = 0, exp_dac = MID;
    int sat_hits = 0;

    task automatic model_step();
        int sum, cd, x, y, c[3], v, d2, d3;
        if (!rst_n) begin
            m_frac = 0; m_int = 0; m_ord = 0; m_res = 0;
            m_s = '{0, 0, 0};
            h2 = '{0}; h3 = '{0, 0};
            exp_div = 0; exp_dac = MID;
        end else begin
            sum = m_res + m_frac;
            cd = sum / FULL;
            x = m_res;
            m_res = sum % FULL;
            exp_div = m_int + cd;
            for (int k = 0; k < 3; k++) begin
                v = m_s[k] + x;
                c[k] = v / FULL;
                m_s[k] = v % FULL;
                x = m_s[k];
            end
            d2 = c[1] - h2[0];
            d3 = c[2] - 2 * h3[0] + h3[1];
            if (m_ord == 0) y = c[0];
            else if (m_ord == 1) y = c[0] + d2;
            else y = c[0] + d2 + d3;
            h2[0] = c[1];
            h3[1] = h3[0];
            h3[0] = c[2];
            v = MID + y * (1 << SH);
            if (v > TOPC) begin
                v = TOPC;
                sat_hits++;
            end
            if (v < 0) v = 0;
            exp_dac = v;
            if (cfg_load) begin
                m_frac = frac_in; m_int = int_in; m_ord = order_in;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        vectors++;
        if (div_val !== exp_div[IW:0] || dac_code !== exp_dac[DW-1:0]) begin
            miscompares++;
            $display("FAIL %s: div_val %0d expected %0d, dac_code %0d expected %0d",
                     phase, div_val, exp_div, dac_code, exp_dac);
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input int fr, input int ig, input int od);
        frac_in = fr[FW-1:0]; int_in = ig[IW-1:0]; order_in = od[1:0];
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    initial begin
        int csum;
        h2 = '{0}; h3 = '{0, 0};
        // R1: reset state
        phase = "R1";
        repeat (3) tick();
        check("R1 div", int'(div_val), 0);
        check("R1 dac", int'(dac_code), MID);
        rst_n = 1'b1;

        // R2: capture edge still uses old settings, next edge uses new
        phase = "R2";
        load(0, 5, 0);
        check("R2 old int", int'(div_val), 0);
        tick();
        check("R2 new int", int'(div_val), 5);

        // R9: first order
        phase = "R9";
        load(32'h9D8A0, 34, 0);
        repeat (400) tick();
        // R7: second order without clearing
        phase = "R7";
        load(32'h9D8A0, 34, 1);
        repeat (400) tick();
        // R10 / R5: third order switched in mid-run
        phase = "R10";
        load(32'h9D8A0, 34, 2);
        repeat (400) tick();
        // R3: extreme fractions
        phase = "R3";
        load(32'hFFFFF, 100, 2);
        repeat (200) tick();
        load(1, 100, 1);
        repeat (200) tick();
        load(0, 7, 2);
        tick();
        repeat (50) begin
            tick();
            check("R3 zero fraction", int'(div_val), 7);
        end

        // R4 / R6 / R8: long run from clear with order code 3
        phase = "R4";
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        phase = "R6";
        load(32'h9D8A0, 34, 3);
        csum = 0;
        sat_hits = 0;
        repeat (65536) begin
            tick();
            csum += int'(div_val) - 34;
        end
        check("R4 carry sum", csum, 32'h9D8A0 / 16);
        check("R8 clamp reached", (sat_hits > 0) ? 1 : 0, 1);

        // R5: another fraction under third order
        phase = "R5";
        load(32'h3C3C3, 12, 2);
        repeat (2000) tick();

        // R1: reset in mid-run
        phase = "R1";
        rst_n = 1'b0;
        tick();
        check("R1 mid-run div", int'(div_val), 0);
        check("R1 mid-run dac", int'(dac_code), MID);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #760000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule